// File: doc/BRIEF.md
# Prescaled Wakeup Timer

This block is a 32-bit up-counting timer that runs on a slow, always-on clock and wakes the rest of the chip after a programmed interval. A control word turns counting on and sets a 12-bit divide ratio. With that ratio the count advances only once every (ratio + 1) enabled clock cycles, so one 32-bit threshold can cover intervals from a few cycles to very long windows. Software can load the count at any time, and the hardware increments the same register.

When the enabled count reaches or passes the threshold, the block sets a sticky interrupt status bit and a sticky wake-cause bit. The wakeup request to the power controller follows the cause bit. The interrupt is cleared by a clear pulse. The cause bit clears only when the value 0 is written to it, and writing 1 leaves it unchanged. All register-style inputs are single-cycle write strobes with data, sampled on the always-on clock.

Top module: `wake_timer`

## Requirements
- R1: After reset the count is 0, the timer is disabled, the threshold is 0, and the interrupt, cause and wakeup request outputs are all 0.
- R2: The control word holds the enable at bit 0 and the divide ratio P at bits 12:1. A write takes effect at the next edge, and from then on the count rises by exactly 1 every P+1 cycles, at edges (P+1), 2(P+1), and so on, counted after the write edge.
- R3: While enable is 0 the count holds its value and the divider returns to zero. After re-enabling, the first increment comes a full P+1 cycles after the enabling write edge.
- R4: A count write loads the written value at the next edge. It takes priority over an increment due in the same cycle, and counting continues from the loaded value.
- R5: The count wraps from 0xFFFFFFFF to 0 on an increment.
- R6: While enabled and count >= threshold, the interrupt status output is 1 from the following edge.
- R7: The interrupt status stays 1 until a clear pulse arrives. If the expiry condition still holds in the same cycle as the clear, the status stays set.
- R8: The cause bit is set together with the interrupt. Only a cause write with data 0 clears it, and a write with data 1 has no effect. When expiry and a clearing write fall in the same cycle, the bit stays set.
- R9: The wakeup request output equals the cause bit.
- R10: While enable is 0, no expiry is detected, even if count >= threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 13 | Bit 0 enable, bits 12:1 divide ratio |
| thold_we | input | 1 | Threshold write strobe |
| thold_wdata | input | 32 | Threshold value |
| count_we | input | 1 | Count write strobe |
| count_wdata | input | 32 | Count value to load |
| intr_clr | input | 1 | Pulse that clears the interrupt status |
| cause_we | input | 1 | Cause write strobe (data 0 clears) |
| cause_wdata | input | 1 | Cause write data |
| count_o | output | 32 | Current count |
| intr_o | output | 1 | Expiry interrupt status |
| cause_o | output | 1 | Sticky wake-cause bit |
| wake_req_o | output | 1 | Wakeup request to the power controller |

## Verification
The assertions check on every cycle that:
- the count either holds, steps by one or takes a loaded value;
- the count wraps at the top value;
- the divider empties while disabled;
- an enabled expiry sets the interrupt on the next edge;
- both flags stay set until their own clear;
- nothing sets while the timer is disabled.

Only the bench scenarios can show the exact divide period for each ratio, including the largest one. They also show the one-cycle gap between the count reaching the threshold and the interrupt rising, the reset of the divider across a short disable, and the outcome when a clear meets a fresh expiry.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    localparam int unsigned DEF_CNT_W = 32;
    localparam int unsigned DEF_PRE_W = 12;
    // position of fields inside the control word
    localparam int unsigned EN_POS  = 0;
    localparam int unsigned PRE_LSB = 1;
endpackage

// File: rtl/wkt_prescale.sv
module wkt_prescale #(
    parameter int unsigned PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] div_d, div_q;

    // a ">=" compare keeps the divider bounded when the limit is lowered mid-run
    assign tick = en && (div_q >= limit);

    always_comb begin
        div_d = div_q;
        if (!en)       div_d = '0;
        else if (tick) div_d = '0;
        else           div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> div_q == '0);
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr)        cnt_d = wdata;       // software load wins
        else if (tick) cnt_d = cnt_q + 1'b1; // natural wrap at all-ones
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> count == $past(count));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> count == $past(wdata));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && count == {CNT_W{1'b1}}) |=> count == '0);
endmodule

// File: rtl/wkt_flags.sv
module wkt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic intr_clr,
    input  logic cause_we,
    input  logic cause_wdata,
    output logic intr,
    output logic cause
);
    typedef struct packed {
        logic intr;
        logic cause;
    } flags_t;

    flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (intr_clr)                  st_d.intr  = 1'b0;
        if (cause_we && !cause_wdata)  st_d.cause = 1'b0;
        // a fresh expiry outranks either clear
        if (expired) begin
            st_d.intr  = 1'b1;
            st_d.cause = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign intr  = st_q.intr;
    assign cause = st_q.cause;

    assert_intr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && !intr_clr) |=> intr);
    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !(cause_we && !cause_wdata)) |=> cause);
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wkt_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned PRE_W = DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [PRE_W:0]   ctrl_wdata,
    input  logic             thold_we,
    input  logic [CNT_W-1:0] thold_wdata,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_wdata,
    input  logic             intr_clr,
    input  logic             cause_we,
    input  logic             cause_wdata,
    output logic [CNT_W-1:0] count_o,
    output logic             intr_o,
    output logic             cause_o,
    output logic             wake_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] thold;
        logic [PRE_W-1:0] ratio;
        logic             en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic tick;
    logic expired;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) begin
            cfg_d.en    = ctrl_wdata[EN_POS];
            cfg_d.ratio = ctrl_wdata[PRE_LSB +: PRE_W];
        end
        if (thold_we) cfg_d.thold = thold_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    wkt_prescale #(.PRE_W(PRE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_q.en),
        .limit (cfg_q.ratio),
        .tick  (tick)
    );

    wkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (count_we),
        .wdata (count_wdata),
        .count (count_o)
    );

    assign expired = cfg_q.en && (count_o >= cfg_q.thold);

    wkt_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .expired     (expired),
        .intr_clr    (intr_clr),
        .cause_we    (cause_we),
        .cause_wdata (cause_wdata),
        .intr        (intr_o),
        .cause       (cause_o)
    );

    assign wake_req_o = cause_o;

    assert_expire_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> intr_o);
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !intr_o) |=> !intr_o);
    assert_wake_from_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> $past(expired));
    assert_step_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !count_we |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));
endmodule

// File: tb/wake_timer_test.sv
module wake_timer_test;
    localparam int CYC = 5; // 200 MHz

    typedef struct packed {
        logic [11:0] p;
        logic [31:0] t;
        logic [15:0] w;
        logic [31:0] c;
        logic        i;
    } vec_t;

    // ratio, threshold, edges waited, expected count, expected interrupt
    localparam vec_t VEC [10] = '{
        '{12'd0,    32'd10, 16'd5,    32'd5,  1'b0},
        '{12'd0,    32'd10, 16'd10,   32'd10, 1'b0},
        '{12'd0,    32'd10, 16'd11,   32'd11, 1'b1},
        '{12'd3,    32'd4,  16'd15,   32'd3,  1'b0},
        '{12'd3,    32'd4,  16'd16,   32'd4,  1'b0},
        '{12'd3,    32'd4,  16'd17,   32'd4,  1'b1},
        '{12'd7,    32'd2,  16'd20,   32'd2,  1'b1},
        '{12'd4095, 32'd1,  16'd4096, 32'd1,  1'b0},
        '{12'd4095, 32'd1,  16'd4097, 32'd1,  1'b1},
        '{12'd0,    32'd0,  16'd1,    32'd1,  1'b1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ctrl_we = 0;
    logic [12:0] ctrl_wdata = '0;
    logic        thold_we = 0;
    logic [31:0] thold_wdata = '0;
    logic        count_we = 0;
    logic [31:0] count_wdata = '0;
    logic        intr_clr = 0;
    logic        cause_we = 0;
    logic        cause_wdata = 0;
    logic [31:0] count_o;
    logic        intr_o, cause_o, wake_req_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CYC/2.0) clk = ~clk;

    wake_timer uut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .thold_we(thold_we), .thold_wdata(thold_wdata),
        .count_we(count_we), .count_wdata(count_wdata),
        .intr_clr(intr_clr), .cause_we(cause_we), .cause_wdata(cause_wdata),
        .count_o(count_o), .intr_o(intr_o), .cause_o(cause_o), .wake_req_o(wake_req_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all drive tasks enter and leave at a falling edge
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(bit en, logic [11:0] p);
        ctrl_we = 1; ctrl_wdata = {p, en};
        @(negedge clk);
        ctrl_we = 0;
    endtask

    task automatic wr_count(logic [31:0] v);
        count_we = 1; count_wdata = v;
        @(negedge clk);
        count_we = 0;
    endtask

    task automatic wr_cause(bit v);
        cause_we = 1; cause_wdata = v;
        @(negedge clk);
        cause_we = 0;
    endtask

    task automatic pulse_clr();
        intr_clr = 1;
        @(negedge clk);
        intr_clr = 0;
    endtask

    // disable and zero the count, then load threshold and clear both flags
    task automatic setup(logic [31:0] t);
        ctrl_we = 1; ctrl_wdata = '0; count_we = 1; count_wdata = '0;
        @(negedge clk);
        ctrl_we = 0; count_we = 0;
        thold_we = 1; thold_wdata = t; intr_clr = 1; cause_we = 1; cause_wdata = 0;
        @(negedge clk);
        thold_we = 0; intr_clr = 0; cause_we = 0;
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 intr", {31'b0, intr_o}, 0);
        chk("R1 wake", {31'b0, wake_req_o}, 0);
        cyc(5);
        chk("R1 idle count", count_o, 0);

        // R2 R6 R8 R9 divide period and expiry timing
        foreach (VEC[k]) begin
            setup(VEC[k].t);
            wr_ctrl(1'b1, VEC[k].p);
            cyc(int'(VEC[k].w));
            chk("R2 count", count_o, VEC[k].c);
            chk("R6 intr", {31'b0, intr_o}, {31'b0, VEC[k].i});
            chk("R9 wake", {31'b0, wake_req_o}, {31'b0, VEC[k].i});
        end

        // R3 count holds while disabled
        setup(32'd1000);
        wr_ctrl(1'b1, 12'd0);
        cyc(5);
        wr_ctrl(1'b0, 12'd0);
        cyc(10);
        chk("R3 hold", count_o, 6);

        // R3 divider restarts after a short disable
        setup(32'd1000);
        wr_ctrl(1'b1, 12'd3);
        cyc(2);
        wr_ctrl(1'b0, 12'd3);
        wr_ctrl(1'b1, 12'd3);
        cyc(3);
        chk("R3 divider reset", count_o, 0);
        cyc(1);
        chk("R3 first step", count_o, 1);

        // R4 software write beats increment
        setup(32'd1000);
        wr_ctrl(1'b1, 12'd0);
        cyc(3);
        wr_count(32'd100);
        chk("R4 load", count_o, 100);
        cyc(1);
        chk("R4 continue", count_o, 101);

        // R5 wrap, R6 at the top threshold
        setup(32'hFFFF_FFFF);
        wr_count(32'hFFFF_FFFE);
        wr_ctrl(1'b1, 12'd0);
        cyc(1);
        chk("R5 top", count_o, 32'hFFFF_FFFF);
        chk("R6 not yet", {31'b0, intr_o}, 0);
        cyc(1);
        chk("R5 wrap", count_o, 0);
        chk("R6 top thold", {31'b0, intr_o}, 1);

        // R7 R8 R9 stickiness and clearing
        wr_ctrl(1'b0, 12'd0);
        cyc(5);
        chk("R7 sticky", {31'b0, intr_o}, 1);
        pulse_clr();
        chk("R7 cleared", {31'b0, intr_o}, 0);
        chk("R8 cause kept", {31'b0, cause_o}, 1);
        wr_cause(1'b1);
        chk("R8 write1 ignored", {31'b0, cause_o}, 1);
        chk("R9 wake on", {31'b0, wake_req_o}, 1);
        wr_cause(1'b0);
        chk("R8 write0 clears", {31'b0, cause_o}, 0);
        chk("R9 wake off", {31'b0, wake_req_o}, 0);

        // R7 R8 expiry outranks a simultaneous clear
        setup(32'd5);
        wr_count(32'd50);
        wr_ctrl(1'b1, 12'd0);
        cyc(1);
        chk("R6 above thold", {31'b0, intr_o}, 1);
        intr_clr = 1; cause_we = 1; cause_wdata = 0;
        @(negedge clk);
        intr_clr = 0; cause_we = 0;
        chk("R7 set wins", {31'b0, intr_o}, 1);
        chk("R8 set wins", {31'b0, cause_o}, 1);

        // R10 no expiry while disabled
        setup(32'd0);
        cyc(10);
        chk("R10 intr off", {31'b0, intr_o}, 0);
        chk("R10 wake off", {31'b0, wake_req_o}, 0);
        wr_ctrl(1'b1, 12'd0);
        cyc(1);
        chk("R10 enabled fires", {31'b0, intr_o}, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule